// File: doc/BRIEF.md
# Keyed Permutation Core

The block applies a keyed nonlinear permutation to a large state. The state is made of twelve 32-bit A words, sixteen 32-bit B words and sixteen 32-bit C words, and a sixteen-word message block acts as the key. A single start pulse latches all operands. The core first rotates every B word. It then runs 48 sequential element updates, one per clock. Each update mixes the current A word, the previous A word, one C word, four B words and one message word, using multiplication by 3 and by 5 modulo 2^32. Each update rewrites one A word and one B word. Finally, 36 modular additions fold C words back into A.

The C words are only read. The surrounding logic is responsible for message buffering, the block counter, padding and the exchange of B and C between calls; it presents operands, pulses start and collects the updated A and B arrays when done pulses. Word k of every bus sits at bits [32k+31:32k].

Top module: `kperm_core`

## Requirements
- R1: A start pulse while busy is low is accepted at that clock edge. It latches the A, C and message words unchanged and every B word rotated left by 17 bits. busy reads 1 from the next cycle on.
- R2: Updates i = 0..47 run in increasing order. Update i replaces A[i mod 12] with ((A[i mod 12] ^ C[(8-i) mod 16] ^ 5*rotl(A[(i+11) mod 12],15)) * 3) ^ B[(i+13) mod 16] ^ (B[(i+9) mod 16] & ~B[(i+6) mod 16]) ^ M[i mod 16]. All products wrap modulo 2^32, and every update sees the words written by earlier updates.
- R3: After the A write of update i, B[i mod 16] becomes ~(rotl(B[i mod 16],1) ^ newA), using the A value just written.
- R4: After the last update, for j = 0..35, A[(11-j) mod 12] is increased by C[(6-j) mod 16] modulo 2^32. These additions change no B word.
- R5: done is high for exactly one cycle. It rises on the 84th clock edge after the edge that accepted start. busy is low whenever done is high.
- R6: While busy is high, start and all operand inputs are ignored. The run completes with the result of the operands latched at acceptance, and no extra done pulse appears.
- R7: a_out and b_out hold their values from the done pulse until the next accepted start, whatever the operand inputs do.
- R8: After reset, busy, done, a_out and b_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a permutation with the present operands |
| a_in | input | 384 | Initial A words, word k at [32k+31:32k] |
| b_in | input | 512 | Initial B words |
| c_in | input | 512 | C words, read only |
| m_in | input | 512 | Message (key) words |
| busy | output | 1 | A permutation is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| a_out | output | 384 | Current A words |
| b_out | output | 512 | Current B words |

## Verification
The embedded assertions check the following on every cycle:
- the single-cycle shape of done and that it follows the last fold;
- that busy only rises after start;
- that the update and fold indices step in their prescribed directions;
- that the latched C and message words hold while busy;
- that folds leave B untouched;
- that outputs hold while idle without a start.

The data results can only be shown by the bench's scenarios, which compare full A and B results against an independent model of the equations. Those scenarios cover all-zero operands, all-ones operands that exercise the modular wrap, and random vectors run back to back. They also cover a start pulse with new operands injected mid-run, and exact done latency.

// File: rtl/kperm_pkg.sv
package kperm_pkg;
  localparam int WORD_W       = 32;
  localparam int NUM_A        = 12;
  localparam int NUM_B        = 16;
  localparam int NUM_UPD      = 48;
  localparam int NUM_FOLD     = 36;
  localparam int PRE_ROT      = 17;
  localparam int PREV_ROT     = 15;
  localparam int SELF_ROT     = 1;
  localparam int TAP_X        = 13;
  localparam int TAP_Y        = 9;
  localparam int TAP_Z        = 6;
  localparam int C_UPD_START  = 8;
  localparam int C_FOLD_START = 6;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {PH_IDLE, PH_UPD, PH_FOLD} phase_t;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  // shift-and-add products, modulo 2^WORD_W
  function automatic word_t times3(input word_t x);
    return x + (x << 1);
  endfunction

  function automatic word_t times5(input word_t x);
    return x + (x << 2);
  endfunction

  function automatic word_t mix_a(input word_t a_cur, input word_t a_prev,
                                  input word_t c_tap, input word_t bx,
                                  input word_t by, input word_t bz,
                                  input word_t m_word);
    word_t inner;
    inner = a_cur ^ c_tap ^ times5(rotl(a_prev, PREV_ROT));
    return times3(inner) ^ bx ^ (by & ~bz) ^ m_word;
  endfunction

  function automatic word_t mix_b(input word_t b_self, input word_t a_new);
    return ~(rotl(b_self, SELF_ROT) ^ a_new);
  endfunction
endpackage

// File: rtl/kperm_ctrl.sv
module kperm_ctrl
  import kperm_pkg::*;
#(
  parameter int N_A     = NUM_A,
  parameter int N_B     = NUM_B,
  parameter int N_UPD   = NUM_UPD,
  parameter int N_FOLD  = NUM_FOLD,
  parameter int C_UPD0  = C_UPD_START,
  parameter int C_FOLD0 = C_FOLD_START,
  localparam int AIW    = $clog2(N_A),
  localparam int BIW    = $clog2(N_B),
  localparam int CW     = $clog2((N_UPD > N_FOLD) ? N_UPD : N_FOLD)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           load,
  output logic           upd_en,
  output logic           fold_en,
  output logic           busy,
  output logic           done,
  output logic [AIW-1:0] a_idx,
  output logic [AIW-1:0] a_prev_idx,
  output logic [BIW-1:0] b_idx,
  output logic [BIW-1:0] c_idx
);
  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          upd_last;
  logic          fold_last;
  logic [AIW-1:0] a_inc;
  logic [AIW-1:0] a_dec;

  assign busy      = (ph != PH_IDLE);
  assign load      = (ph == PH_IDLE) && start;
  assign upd_en    = (ph == PH_UPD);
  assign fold_en   = (ph == PH_FOLD);
  assign upd_last  = upd_en  && (cnt == CW'(N_UPD - 1));
  assign fold_last = fold_en && (cnt == CW'(N_FOLD - 1));

  assign a_inc      = (a_idx == AIW'(N_A - 1)) ? '0 : a_idx + 1'b1;
  assign a_dec      = (a_idx == '0) ? AIW'(N_A - 1) : a_idx - 1'b1;
  assign a_prev_idx = a_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      a_idx <= '0;
      b_idx <= '0;
      c_idx <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            ph    <= PH_UPD;
            cnt   <= '0;
            a_idx <= '0;
            b_idx <= '0;
            c_idx <= BIW'(C_UPD0);
          end
        end
        PH_UPD: begin
          b_idx <= b_idx + 1'b1;
          if (upd_last) begin
            ph    <= PH_FOLD;
            cnt   <= '0;
            a_idx <= AIW'(N_A - 1);
            c_idx <= BIW'(C_FOLD0);
          end else begin
            cnt   <= cnt + 1'b1;
            a_idx <= a_inc;
            c_idx <= c_idx - 1'b1;
          end
        end
        PH_FOLD: begin
          if (fold_last) begin
            ph   <= PH_IDLE;
            done <= 1'b1;
          end else begin
            cnt   <= cnt + 1'b1;
            a_idx <= a_dec;
            c_idx <= c_idx - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: done only follows a fold cycle
  a_r5_done_after_fold: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fold_en));
  // R1: busy rises only after a start
  a_r1_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R6: start during an update never restarts the run
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && start) |=> (upd_en || fold_en));
  // R2: update indices advance by one each cycle
  a_r2_update_order: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && $past(upd_en)) |-> (b_idx == $past(b_idx) + 1'b1));
  // R2: A index stays inside the array
  a_r2_a_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(a_idx) < N_A));
  // R4: fold C index walks downward
  a_r4_fold_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_en && $past(fold_en)) |-> (c_idx == $past(c_idx) - 1'b1));
endmodule

// File: rtl/kperm_elem.sv
module kperm_elem
  import kperm_pkg::*;
(
  input  word_t a_cur,
  input  word_t a_prev,
  input  word_t c_tap,
  input  word_t b_self,
  input  word_t b_x,
  input  word_t b_y,
  input  word_t b_z,
  input  word_t m_word,
  output word_t a_new,
  output word_t b_new
);
  always_comb begin
    a_new = mix_a(a_cur, a_prev, c_tap, b_x, b_y, b_z, m_word);
    b_new = mix_b(b_self, a_new);
  end
endmodule

// File: rtl/kperm_fold.sv
module kperm_fold
  import kperm_pkg::*;
(
  input  word_t a_cur,
  input  word_t c_tap,
  output word_t a_sum
);
  assign a_sum = a_cur + c_tap;
endmodule

// File: rtl/kperm_core.sv
module kperm_core
  import kperm_pkg::*;
#(
  parameter int N_A    = NUM_A,
  parameter int N_B    = NUM_B,
  parameter int N_UPD  = NUM_UPD,
  parameter int N_FOLD = NUM_FOLD,
  localparam int AW    = N_A * WORD_W,
  localparam int BW    = N_B * WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] a_in,
  input  logic [BW-1:0] b_in,
  input  logic [BW-1:0] c_in,
  input  logic [BW-1:0] m_in,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] a_out,
  output logic [BW-1:0] b_out
);
  localparam int AIW = $clog2(N_A);
  localparam int BIW = $clog2(N_B);

  word_t a_q [N_A];
  word_t b_q [N_B];
  word_t c_q [N_B];
  word_t m_q [N_B];

  word_t a_in_w   [N_A];
  word_t b_in_rot [N_B];
  word_t c_in_w   [N_B];
  word_t m_in_w   [N_B];

  logic [BW-1:0] c_view;
  logic [BW-1:0] m_view;

  // named internal events
  logic load_fire, upd_fire, fold_fire;
  logic [AIW-1:0] a_idx, a_prev_idx;
  logic [BIW-1:0] b_idx, c_idx, tap_x, tap_y, tap_z;
  word_t a_new, b_new, a_sum;

  kperm_ctrl #(
    .N_A(N_A), .N_B(N_B), .N_UPD(N_UPD), .N_FOLD(N_FOLD),
    .C_UPD0(C_UPD_START), .C_FOLD0(C_FOLD_START)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load_fire), .upd_en(upd_fire), .fold_en(fold_fire),
    .busy(busy), .done(done),
    .a_idx(a_idx), .a_prev_idx(a_prev_idx),
    .b_idx(b_idx), .c_idx(c_idx)
  );

  assign tap_x = b_idx + BIW'(TAP_X);
  assign tap_y = b_idx + BIW'(TAP_Y);
  assign tap_z = b_idx + BIW'(TAP_Z);

  kperm_elem u_elem (
    .a_cur(a_q[a_idx]), .a_prev(a_q[a_prev_idx]), .c_tap(c_q[c_idx]),
    .b_self(b_q[b_idx]), .b_x(b_q[tap_x]), .b_y(b_q[tap_y]), .b_z(b_q[tap_z]),
    .m_word(m_q[b_idx]), .a_new(a_new), .b_new(b_new)
  );

  kperm_fold u_fold (
    .a_cur(a_q[a_idx]), .c_tap(c_q[c_idx]), .a_sum(a_sum)
  );

  for (genvar g = 0; g < N_A; g++) begin : g_a_words
    assign a_in_w[g] = a_in[g*WORD_W +: WORD_W];
    assign a_out[g*WORD_W +: WORD_W] = a_q[g];
  end

  for (genvar g = 0; g < N_B; g++) begin : g_b_words
    assign b_in_rot[g] = rotl(b_in[g*WORD_W +: WORD_W], PRE_ROT);
    assign c_in_w[g]   = c_in[g*WORD_W +: WORD_W];
    assign m_in_w[g]   = m_in[g*WORD_W +: WORD_W];
    assign b_out[g*WORD_W +: WORD_W]  = b_q[g];
    assign c_view[g*WORD_W +: WORD_W] = c_q[g];
    assign m_view[g*WORD_W +: WORD_W] = m_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_A; k++) a_q[k] <= '0;
      for (int k = 0; k < N_B; k++) begin
        b_q[k] <= '0;
        c_q[k] <= '0;
        m_q[k] <= '0;
      end
    end else if (load_fire) begin
      for (int k = 0; k < N_A; k++) a_q[k] <= a_in_w[k];
      for (int k = 0; k < N_B; k++) begin
        b_q[k] <= b_in_rot[k];
        c_q[k] <= c_in_w[k];
        m_q[k] <= m_in_w[k];
      end
    end else if (upd_fire) begin
      a_q[a_idx] <= a_new;
      b_q[b_idx] <= b_new;
    end else if (fold_fire) begin
      a_q[a_idx] <= a_sum;
    end
  end

  // R6: latched C and message words do not move during a run
  a_r6_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(c_view) && $stable(m_view)));
  // R7: outputs hold while idle and no start is seen
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(a_out) && $stable(b_out)));
  // R4: folds leave B alone
  a_r4_fold_keeps_b: assert property (@(posedge clk) disable iff (!rst_n)
    fold_fire |=> $stable(b_out));
  // R1: the load edge makes busy visible
  a_r1_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> busy);
endmodule

// File: tb/kperm_core_test.sv
`timescale 1ns/1ps
module kperm_core_test;
  localparam int AW  = 12 * 32;
  localparam int BW  = 16 * 32;
  localparam int LAT = 84;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [BW-1:0] b;
    int            t0;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic [BW-1:0] b_in = '0, c_in = '0, m_in = '0;
  logic busy, done;
  logic [AW-1:0] a_out;
  logic [BW-1:0] b_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int jobs = 0;
  int dones = 0;
  int unsigned seed = 32'h1234_5678;
  exp_t sbq[$];
  logic [AW-1:0] last_a = '0;
  logic [BW-1:0] last_b = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  kperm_core uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .m_in(m_in),
    .busy(busy), .done(done), .a_out(a_out), .b_out(b_out)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic rnd(output int unsigned v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  task automatic rnd_bus(output logic [BW-1:0] v);
    int unsigned w;
    for (int k = 0; k < 16; k++) begin
      rnd(w);
      v[k*32 +: 32] = w;
    end
  endtask

  // independent model of the update equations
  task automatic model(input logic [AW-1:0] ai, input logic [BW-1:0] bi,
                       input logic [BW-1:0] ci, input logic [BW-1:0] mi,
                       output logic [AW-1:0] ao, output logic [BW-1:0] bo);
    int unsigned ma[12];
    int unsigned mb[16];
    int unsigned mc[16];
    int unsigned mm[16];
    int unsigned p, u;
    for (int k = 0; k < 12; k++) ma[k] = ai[k*32 +: 32];
    for (int k = 0; k < 16; k++) begin
      mb[k] = bi[k*32 +: 32];
      mb[k] = (mb[k] >> 15) | (mb[k] << 17);
      mc[k] = ci[k*32 +: 32];
      mm[k] = mi[k*32 +: 32];
    end
    for (int i = 0; i < 48; i++) begin
      p = ma[(i + 11) % 12];
      p = (p << 15) | (p >> 17);
      u = (ma[i % 12] ^ mc[(56 - i) % 16] ^ (p * 32'd5)) * 32'd3;
      ma[i % 12] = u ^ mb[(i + 13) % 16] ^ (mb[(i + 9) % 16] & ~mb[(i + 6) % 16])
                   ^ mm[i % 16];
      mb[i % 16] = ~(((mb[i % 16] << 1) | (mb[i % 16] >> 31)) ^ ma[i % 12]);
    end
    for (int j = 0; j < 36; j++)
      ma[(47 - j) % 12] = ma[(47 - j) % 12] + mc[(54 - j) % 16];
    for (int k = 0; k < 12; k++) ao[k*32 +: 32] = ma[k];
    for (int k = 0; k < 16; k++) bo[k*32 +: 32] = mb[k];
  endtask

  // driver: push expected item, then start the run
  task automatic run_job(input logic [AW-1:0] ai, input logic [BW-1:0] bi,
                         input logic [BW-1:0] ci, input logic [BW-1:0] mi);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    model(ai, bi, ci, mi, e.a, e.b);
    a_in = ai; b_in = bi; c_in = ci; m_in = mi;
    start = 1'b1;
    @(posedge clk);
    #1;
    e.t0 = cyc;
    sbq.push_back(e);
    jobs++;
    chk(busy == 1'b1, "R1 busy after accepted start", BW'(busy), BW'(1));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  // monitor: compare results as they appear
  initial begin
    exp_t e;
    bit prev_done = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (prev_done)
        chk(!done, "R5 done lasts one cycle", BW'(done), BW'(0));
      if (done) begin
        dones++;
        chk(!busy, "R5 busy low with done", BW'(busy), BW'(0));
        if (sbq.size() == 0) begin
          chk(1'b0, "R6 unexpected done", BW'(1), BW'(0));
        end else begin
          e = sbq.pop_front();
          chk(a_out == e.a, "R2 R4 A result", BW'(a_out), BW'(e.a));
          chk(b_out == e.b, "R3 B result", b_out, e.b);
          chk(cyc - e.t0 == LAT, "R5 done latency", BW'(cyc - e.t0), BW'(LAT));
          last_a = a_out;
          last_b = b_out;
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [BW-1:0] ra, rb, rc, rm;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(busy == 1'b0, "R8 busy in reset", BW'(busy), BW'(0));
    chk(done == 1'b0, "R8 done in reset", BW'(done), BW'(0));
    chk(a_out == '0, "R8 a_out in reset", BW'(a_out), BW'(0));
    chk(b_out == '0, "R8 b_out in reset", b_out, BW'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3: all-zero operands
    run_job('0, '0, '0, '0);
    // R2: all-ones operands exercise modular wrap
    run_job('1, '1, '1, '1);
    // R2 R3 R4: random operands, back to back
    for (int n = 0; n < 3; n++) begin
      rnd_bus(ra); rnd_bus(rb); rnd_bus(rc); rnd_bus(rm);
      run_job(ra[AW-1:0], rb, rc, rm);
    end
    // R2: sparse single-bit patterns
    run_job(AW'(1) << 200, BW'(1) << 37, BW'(1) << 511, BW'(1) << 5);
    drain();

    // R7: outputs hold while inputs move and start stays low
    for (int n = 0; n < 10; n++) begin
      rnd_bus(ra); rnd_bus(rb);
      a_in = ra[AW-1:0]; b_in = rb; c_in = rb; m_in = ra;
      @(negedge clk);
    end
    chk(busy == 1'b0, "R7 stays idle without start", BW'(busy), BW'(0));
    chk(a_out == last_a, "R7 a_out held", BW'(a_out), BW'(last_a));
    chk(b_out == last_b, "R7 b_out held", b_out, last_b);

    // R6: start and new operands mid-run are ignored
    rnd_bus(ra); rnd_bus(rb); rnd_bus(rc); rnd_bus(rm);
    run_job(ra[AW-1:0], rb, rc, rm);
    repeat (20) @(negedge clk);
    rnd_bus(ra); rnd_bus(rb);
    a_in = ra[AW-1:0]; b_in = rb; c_in = ra; m_in = rb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (100) @(negedge clk);
    chk(dones == jobs, "R6 one done per accepted start", BW'(dones), BW'(jobs));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule